// File: doc/BRIEF.md
# Frame-Synchronized Serial DAC Word Loader

This block sits between a transceiver DSP core and a transmit DAC. The core sends a stream of two's-complement samples over three wires: a bit clock, a frame sync and a serial data line. Each sample is a 16-bit word, sent most significant bit first. The loader keeps the leading 12 bits of each word as the DAC code. It passes that code to a parallel holding register only when the frame sync falls, so the DAC output changes at a well-defined point in each frame.

All logic runs on the serial bit clock, which is also the block's clock. Both serial inputs are sampled on its rising edge. The frame sync may rise at any point in a frame and may stay high for any number of cycles, as long as it is high for at least one. The cycle in which the sync is first seen low again marks the end of the word. The data bit sampled in that same cycle is the most significant bit of the next word. If a word ends before 12 bits have arrived, a one-cycle framing-error pulse is raised and the previous code is kept. The reset is asynchronous and active low, and the block releases it on the serial clock.

Top module: `ser_dac_loader`

## Requirements
- R1: While reset is applied, and after it is released until the first load, `dac_code_o` is the mid-scale code 12'h000 (two's complement zero), and `load_o` and `frame_err_o` are 0.
- R2: Bits arrive MSB first. The first serial bit of a word becomes bit 11 of `dac_code_o`, and the twelfth bit becomes bit 0.
- R3: Serial bits 13 to 16 of a word have no effect on the loaded code.
- R4: A sync fall is a rising clock edge at which `fsync_i` is sampled 0 after being sampled 1 at the previous edge. `dac_code_o` changes only in the cycle that follows such an edge, and `load_o` is high for exactly that one cycle.
- R5: The point at which `fsync_i` rises within a frame, and how long it stays high (one cycle or more), do not change the loaded code.
- R6: The data bit sampled at the sync-fall edge is taken as the MSB of the next word.
- R7: If fewer than 12 bits were captured before a sync fall, `frame_err_o` pulses for one cycle, `load_o` stays 0 and `dac_code_o` keeps its previous value.
- R8: A word of exactly 12 bits before the sync fall loads normally.
- R9: If more than 16 bits arrive before a sync fall, the extra bits are ignored and the first 12 bits are loaded.
- R10: `load_o` and `frame_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync; its falling edge commits the current word |
| sdata_i | input | 1 | Serial two's-complement data, MSB first |
| dac_code_o | output | 12 | Parallel DAC code holding register |
| load_o | output | 1 | One-cycle pulse, high in the cycle the code is updated |
| frame_err_o | output | 1 | One-cycle pulse for a word shorter than 12 bits |

## Verification
Two cases are hard to reach from the ports: a sync fall that lands inside the next word's first cycle, and frame lengths right at 12 bits or beyond 16. In the stimulus, each word's MSB is sent in the same cycle as the previous word's sync fall, so frames follow one another with no gap. Random frame lengths are drawn from three bands: short (2 to 11 bits), nominal (12 to 16) and overlong (17 to 24). The sync rise point is drawn anywhere inside the frame. Directed frames cover exactly 12 bits, 11 bits, 20 bits, a sync held high for almost the whole word, and words with different trailing bits.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  // Outcome decided at each clock edge for the word collected so far
  typedef enum logic [1:0] {
    VERDICT_NONE  = 2'd0,
    VERDICT_LOAD  = 2'd1,
    VERDICT_SHORT = 2'd2
  } verdict_e;

  function automatic verdict_e judge_word(input logic fall, input logic enough);
    verdict_e v;
    if (!fall)       v = VERDICT_NONE;
    else if (enough) v = VERDICT_LOAD;
    else             v = VERDICT_SHORT;
    return v;
  endfunction

endpackage

// File: rtl/ldr_rst_sync.sv
module ldr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ldr_sync_edge.sv
module ldr_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_i,
  output logic fall_o
);

  logic fsync_q;
  logic fsync_d;

  always_comb begin
    fsync_d = fsync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsync_q <= 1'b0;
    else        fsync_q <= fsync_d;
  end

  // High for the edge at which sync is seen low after being seen high
  assign fall_o = fsync_q & ~fsync_i;

endmodule

// File: rtl/ldr_bit_capture.sv
module ldr_bit_capture #(
  parameter int WORD_W = 16,
  parameter int KEEP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              sdata_i,
  output logic [KEEP_W-1:0] cap_o,
  output logic              enough_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] KEEP_C = CNT_W'(KEEP_W);
  localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [KEEP_W-1:0] cap_q, cap_d;
  logic [KEEP_W-1:0] wr_en;

  // Per-bit write enables: bit index falls from MSB as the count rises
  for (genvar i = 0; i < KEEP_W; i++) begin : g_bit
    if (i == KEEP_W - 1) begin : g_msb
      assign wr_en[i] = fall_i | (cnt_q == '0);
    end else begin : g_rest
      assign wr_en[i] = ~fall_i & (cnt_q == CNT_W'(KEEP_W - 1 - i));
    end
    assign cap_d[i] = wr_en[i] ? sdata_i : cap_q[i];
  end

  always_comb begin
    if (fall_i)               cnt_d = ONE_C;
    else if (cnt_q < WORD_C)  cnt_d = cnt_q + ONE_C;
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  assign cap_o    = cap_q;
  assign enough_o = (cnt_q >= KEEP_C);

endmodule

// File: rtl/ldr_out_reg.sv
module ldr_out_reg
  import ldr_pkg::*;
#(
  parameter int                KEEP_W   = 12,
  parameter logic [KEEP_W-1:0] MID_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  verdict_e          verdict_i,
  input  logic [KEEP_W-1:0] cap_i,
  output logic [KEEP_W-1:0] code_o,
  output logic              load_o,
  output logic              err_o
);

  logic [KEEP_W-1:0] code_q, code_d;
  logic              code_en;
  logic              load_q, load_d;
  logic              err_q, err_d;

  always_comb begin
    code_en = (verdict_i == VERDICT_LOAD);
    code_d  = cap_i;
    load_d  = code_en;
    err_d   = (verdict_i == VERDICT_SHORT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID_CODE;
      load_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (code_en) code_q <= code_d;
      load_q <= load_d;
      err_q  <= err_d;
    end
  end

  assign code_o = code_q;
  assign load_o = load_q;
  assign err_o  = err_q;

endmodule

// File: rtl/ser_dac_loader.sv
module ser_dac_loader
  import ldr_pkg::*;
#(
  parameter int                WORD_W   = 16,
  parameter int                KEEP_W   = 12,
  parameter int                RST_STG  = 2,
  parameter logic [KEEP_W-1:0] MID_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic              sdata_i,
  output logic [KEEP_W-1:0] dac_code_o,
  output logic              load_o,
  output logic              frame_err_o
);

  logic              rst_n_int;
  logic              fall;
  logic              enough;
  logic [KEEP_W-1:0] cap;
  verdict_e          verdict;

  ldr_rst_sync #(.STAGES(RST_STG)) rst_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  ldr_sync_edge edge_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .fsync_i (fsync_i),
    .fall_o  (fall)
  );

  ldr_bit_capture #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) cap_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .fall_i   (fall),
    .sdata_i  (sdata_i),
    .cap_o    (cap),
    .enough_o (enough)
  );

  assign verdict = judge_word(fall, enough);

  ldr_out_reg #(.KEEP_W(KEEP_W), .MID_CODE(MID_CODE)) out_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .verdict_i (verdict),
    .cap_i     (cap),
    .code_o    (dac_code_o),
    .load_o    (load_o),
    .err_o     (frame_err_o)
  );

endmodule

// File: rtl/ser_dac_loader_chk.sv
module ser_dac_loader_chk #(
  parameter int KEEP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fsync_i,
  input logic [KEEP_W-1:0] dac_code_o,
  input logic              load_o,
  input logic              frame_err_o
);

  assert_code_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |-> $stable(dac_code_o));

  assert_load_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  assert_pulse_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o || frame_err_o) |-> (!$past(fsync_i) && $past(fsync_i, 2)));

  assert_err_keeps_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> $stable(dac_code_o));

  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_o && frame_err_o));

endmodule

bind ser_dac_loader ser_dac_loader_chk #(.KEEP_W(KEEP_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .fsync_i     (fsync_i),
  .dac_code_o  (dac_code_o),
  .load_o      (load_o),
  .frame_err_o (frame_err_o)
);

// File: tb/ser_dac_loader_tb_top.sv
module ser_dac_loader_tb_top;

  localparam int WORD_W = 16;
  localparam int KEEP_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fsync = 1'b0;
  logic              sdata = 1'b0;
  logic [KEEP_W-1:0] code;
  logic              ld;
  logic              er;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic              m_fsq;
  int                m_cnt;
  logic [KEEP_W-1:0] m_cap;
  logic [KEEP_W-1:0] m_code;
  logic              m_ld;
  logic              m_err;

  always #4 clk = ~clk;

  ser_dac_loader dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync_i     (fsync),
    .sdata_i     (sdata),
    .dac_code_o  (code),
    .load_o      (ld),
    .frame_err_o (er)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One serial bit; model updated from the requirements, then compared
  task automatic step(input logic fs, input logic d);
    @(negedge clk);
    fsync = fs;
    sdata = d;
    @(posedge clk);
    m_ld  = 1'b0;
    m_err = 1'b0;
    if (m_fsq && !fs) begin
      if (m_cnt >= KEEP_W) begin m_code = m_cap; m_ld = 1'b1; end
      else m_err = 1'b1;
      m_cap[KEEP_W-1] = d;
      m_cnt = 1;
    end else begin
      if (m_cnt < KEEP_W) m_cap[KEEP_W-1-m_cnt] = d;
      if (m_cnt < WORD_W) m_cnt++;
    end
    m_fsq = fs;
    #2;
    chk("R4", "code", 32'(code), 32'(m_code));
    chk("R4", "load", 32'(ld), 32'(m_ld));
    chk("R7", "frame_err", 32'(er), 32'(m_err));
    chk("R10", "load&err", 32'(ld & er), 32'd0);
  endtask

  // Frame of n bits from w (MSB at bit 31); sync high for last h cycles
  task automatic frame(input logic [31:0] w, input int n, input int h, input bit skip);
    for (int i = (skip ? 1 : 0); i < n; i++) step(i >= n - h, w[31-i]);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    logic pend;
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "code in reset", 32'(code), 32'h0);
    chk("R1", "load in reset", 32'(ld), 32'h0);
    chk("R1", "err in reset", 32'(er), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "code after reset", 32'(code), 32'h0);
    chk("R1", "load after reset", 32'(ld), 32'h0);
    chk("R1", "err after reset", 32'(er), 32'h0);
    fsync = 1'b1;
    m_fsq = 1'b1; m_cnt = 0; m_cap = '0; m_code = '0; m_ld = 1'b0; m_err = 1'b0;

    step(1'b0, 1'b1);  // flush: short frame error, MSB 1 of next word
    chk("R7", "flush err", 32'(er), 32'h1);

    frame(32'hA5C3_0000, 16, 3, 1); step(1'b0, 1'b0);
    chk("R2", "code", 32'(code), 32'hA5C);
    chk("R2", "load", 32'(ld), 32'h1);

    frame(32'h5A5F_0000, 16, 2, 1); step(1'b0, 1'b1);
    chk("R3", "code", 32'(code), 32'h5A5);

    frame(32'hFFF0_0000, 12, 1, 1); step(1'b0, 1'b1);
    chk("R8", "code", 32'(code), 32'hFFF);
    chk("R8", "load", 32'(ld), 32'h1);

    frame(32'h8000_0000, 11, 4, 1); step(1'b0, 1'b0);
    chk("R7", "err", 32'(er), 32'h1);
    chk("R7", "load", 32'(ld), 32'h0);
    chk("R7", "code kept", 32'(code), 32'hFFF);

    frame(32'h0123_4567, 20, 5, 1); step(1'b0, 1'b1);
    chk("R9", "code", 32'(code), 32'h012);

    frame(32'h8AB0_0000, 16, 15, 1); step(1'b0, 1'b0);
    chk("R5", "code", 32'(code), 32'h8AB);

    frame(32'h7010_0000, 16, 1, 1); step(1'b0, 1'b1);
    chk("R6", "code", 32'(code), 32'h701);

    pend = 1'b1;
    for (int f = 0; f < 400; f++) begin
      int n, h, sel;
      logic [31:0] w;
      sel = int'($urandom % 100);
      if (sel < 15)      n = 2 + int'($urandom % 10);
      else if (sel < 30) n = 17 + int'($urandom % 8);
      else               n = 12 + int'($urandom % 5);
      h = 1 + int'($urandom % (n - 1));
      w = $urandom;
      w[31] = pend;
      frame(w, n, h, 1);
      pend = 1'($urandom % 2);
      step(1'b0, pend);
    end
    finish_run();
  end

endmodule